// File: doc/BRIEF.md
# Memory-Mapped Transfer Descriptor Launcher

This block holds the fields of one outgoing transfer in a small set of 32-bit registers. A processor writes them over a simple configuration bus. The fields are the local buffer address, the remote target address, the byte count, the target device identifier, the packet priority and the transaction kind. Writing the kind into the command register launches the transfer. The block copies every field, takes a transaction tag from its own tag pool, and offers the result to a downstream header builder through a valid/ready handshake.

Tags come from a free-running 8-bit pointer. The pointer skips tags that still wait for a response. Kinds that expect a response keep their tag reserved until a completion pulse returns it. A status word reports three things: the launcher is busy, an illegal kind was written, or a launch was attempted while busy. The two error bits are sticky and are cleared by writing ones to them.

Top module: `tdl_launcher`

## Requirements
- R1: After reset, `req_valid` and `busy` are 0, and every descriptor register and the status word read as 0.
- R2: Register map by index: 0 local address, 1 remote address, 2 byte count, 3 device id in bits [15:0], 4 priority in bits [1:0], 5 command with the kind in bits [2:0], 6 status (bit 0 busy, bit 1 illegal-kind, bit 2 overrun). A read with `cfg_rd_en` returns data on `cfg_rdata` one cycle later.
- R3: A write to index 5 while idle, with kind 0..5, launches a transfer. `busy` is 1 from the next cycle. `req_valid` rises one cycle after that. The request carries the register contents as they were at the launch write.
- R4: Writes to indices 0 to 4 never launch a transfer. `busy` and `req_valid` stay 0.
- R5: Kind codes are 0 read, 1 write, 2 write-with-response, 3 streaming write, 4 atomic and 5 maintenance. A launch write with code 6 or 7 does not launch and sets status bit 1.
- R6: A launch write while `busy` is 1 is dropped and sets status bit 2. Writing index 6 with bit 1 or bit 2 set clears the matching flag.
- R7: While `req_valid` is 1 and `req_ready` is 0, every request field holds its value, even when the descriptor registers are rewritten.
- R8: `busy` and `req_valid` drop in the cycle after the handshake edge (`req_valid` and `req_ready` both 1).
- R9: Tags are handed out in increasing order from 0, wrapping after 255. Kinds 1 and 3 release their tag at once.
- R10: Kinds 0, 2, 4 and 5 keep their tag reserved, and the pointer skips it on later launches. A `cpl_valid` pulse with that tag in `cpl_tid` releases it for reuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cpl_valid | input | 1 | Completion pulse |
| cpl_tid | input | 8 | Tag being returned |
| req_valid | output | 1 | Request offered to the header builder |
| req_ready | input | 1 | Header builder accepts the request |
| req_kind | output | 3 | Transaction kind |
| req_tid | output | 8 | Hardware-assigned tag |
| req_local_addr | output | 32 | Local buffer address |
| req_remote_addr | output | 32 | Remote target address |
| req_dest_id | output | 16 | Target device id |
| req_byte_count | output | 32 | Transfer length in bytes |
| req_prio | output | 2 | Packet priority |
| busy | output | 1 | A launch is in progress |

## Verification
The bench holds the header builder off and rewrites the descriptors under a pending request. A launcher that forwards live registers instead of a snapshot would change fields while valid is high. It issues a second launch while busy and illegal kind codes. A design that queued the launch, or accepted codes 6 or 7, would produce an extra request and no error flag. One response-type tag is kept reserved across a full wrap of the pointer. A pointer that did not skip it would hand out a duplicate tag, and one that ignored the completion would never reuse the tag.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  localparam int REG_W = 32;

  // register indices; index 5 is the launch trigger
  localparam logic [2:0] IDX_LOCAL  = 3'd0;
  localparam logic [2:0] IDX_REMOTE = 3'd1;
  localparam logic [2:0] IDX_COUNT  = 3'd2;
  localparam logic [2:0] IDX_DEST   = 3'd3;
  localparam logic [2:0] IDX_PRIO   = 3'd4;
  localparam logic [2:0] IDX_LAUNCH = 3'd5;
  localparam logic [2:0] IDX_STATUS = 3'd6;

  typedef enum logic [2:0] {
    KIND_READ     = 3'd0,
    KIND_WRITE    = 3'd1,
    KIND_WRITE_RS = 3'd2,
    KIND_STREAM   = 3'd3,
    KIND_ATOMIC   = 3'd4,
    KIND_MAINT    = 3'd5
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEEK  = 2'd1,
    ST_OFFER = 2'd2
  } launch_state_e;

  function automatic logic kind_legal(input logic [2:0] k);
    return k <= KIND_MAINT;
  endfunction

  function automatic logic kind_holds_tag(input logic [2:0] k);
    return (k == KIND_READ) || (k == KIND_WRITE_RS) ||
           (k == KIND_ATOMIC) || (k == KIND_MAINT);
  endfunction

endpackage

// File: rtl/tdl_desc_regs.sv
module tdl_desc_regs
  import tdl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DEST_W = 16,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  status_word,
  output logic [ADDR_W-1:0] local_q,
  output logic [ADDR_W-1:0] remote_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [DEST_W-1:0] dest_q,
  output logic [PRIO_W-1:0] prio_q,
  output logic [2:0]        kind_q,
  output logic [REG_W-1:0]  rd_data
);

  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      local_q  <= '0;
      remote_q <= '0;
      count_q  <= '0;
      dest_q   <= '0;
      prio_q   <= '0;
      kind_q   <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_LOCAL:  local_q  <= wr_data[ADDR_W-1:0];
        IDX_REMOTE: remote_q <= wr_data[ADDR_W-1:0];
        IDX_COUNT:  count_q  <= wr_data[CNT_W-1:0];
        IDX_DEST:   dest_q   <= wr_data[DEST_W-1:0];
        IDX_PRIO:   prio_q   <= wr_data[PRIO_W-1:0];
        IDX_LAUNCH: kind_q   <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_LOCAL:  rd_mux[ADDR_W-1:0] = local_q;
      IDX_REMOTE: rd_mux[ADDR_W-1:0] = remote_q;
      IDX_COUNT:  rd_mux[CNT_W-1:0]  = count_q;
      IDX_DEST:   rd_mux[DEST_W-1:0] = dest_q;
      IDX_PRIO:   rd_mux[PRIO_W-1:0] = prio_q;
      IDX_LAUNCH: rd_mux[2:0]        = kind_q;
      IDX_STATUS: rd_mux             = status_word;
      default:    rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R2
  local_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_LOCAL) |=> local_q == $past(wr_data[ADDR_W-1:0]));

endmodule

// File: rtl/tdl_tid_alloc.sv
module tdl_tid_alloc #(
  parameter int TID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seek,
  input  logic             hold_tag,
  input  logic             cpl_valid,
  input  logic [TID_W-1:0] cpl_tid,
  output logic             tid_free,
  output logic [TID_W-1:0] cand_tid
);

  localparam int NUM_TID = 1 << TID_W;

  logic [NUM_TID-1:0] reserved;
  logic               take;

  assign tid_free = !reserved[cand_tid];
  assign take     = seek && tid_free && hold_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      reserved <= '0;
      cand_tid <= '0;
    end else begin
      if (seek)      cand_tid <= cand_tid + 1'b1;
      if (cpl_valid) reserved[cpl_tid] <= 1'b0;
      if (take)      reserved[cand_tid] <= 1'b1;
    end
  end

  // R10
  tag_kept_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> reserved[$past(cand_tid)]);

  // R10
  tag_freed_chk: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !(take && cand_tid == cpl_tid)) |=> !reserved[$past(cpl_tid)]);

endmodule

// File: rtl/tdl_launch_ctrl.sv
module tdl_launch_ctrl
  import tdl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DEST_W = 16,
  parameter int PRIO_W = 2,
  parameter int TID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_wr,
  input  logic [2:0]        launch_kind,
  input  logic              clear_wr,
  input  logic [2:1]        clear_bits,
  input  logic [ADDR_W-1:0] local_q,
  input  logic [ADDR_W-1:0] remote_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic [DEST_W-1:0] dest_q,
  input  logic [PRIO_W-1:0] prio_q,
  input  logic              tid_free,
  input  logic [TID_W-1:0]  cand_tid,
  input  logic              req_ready,
  output logic              seek,
  output logic              hold_tag,
  output logic              req_valid,
  output logic [2:0]        req_kind,
  output logic [TID_W-1:0]  req_tid,
  output logic [ADDR_W-1:0] req_local,
  output logic [ADDR_W-1:0] req_remote,
  output logic [CNT_W-1:0]  req_count,
  output logic [DEST_W-1:0] req_dest,
  output logic [PRIO_W-1:0] req_prio,
  output logic              busy,
  output logic              err_flag,
  output logic              ovr_flag
);

  launch_state_e state;

  assign seek      = (state == ST_SEEK);
  assign hold_tag  = kind_holds_tag(req_kind);
  assign req_valid = (state == ST_OFFER);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_kind   <= '0;
      req_tid    <= '0;
      req_local  <= '0;
      req_remote <= '0;
      req_count  <= '0;
      req_dest   <= '0;
      req_prio   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (launch_wr && kind_legal(launch_kind)) begin
          state      <= ST_SEEK;
          req_kind   <= launch_kind;
          req_local  <= local_q;
          req_remote <= remote_q;
          req_count  <= count_q;
          req_dest   <= dest_q;
          req_prio   <= prio_q;
        end
        ST_SEEK: if (tid_free) begin
          state   <= ST_OFFER;
          req_tid <= cand_tid;
        end
        ST_OFFER: if (req_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (launch_wr && busy)                                   ovr_flag <= 1'b1;
      else if (clear_wr && clear_bits[2])                      ovr_flag <= 1'b0;
      if (launch_wr && !busy && !kind_legal(launch_kind))      err_flag <= 1'b1;
      else if (clear_wr && clear_bits[1])                      err_flag <= 1'b0;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_tid) && $stable(req_kind)
      && $stable(req_local) && $stable(req_remote) && $stable(req_count)
      && $stable(req_dest) && $stable(req_prio)));

  // R5
  bad_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (launch_wr && !busy && !kind_legal(launch_kind)) |=> (!busy && err_flag));

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (launch_wr && busy) |=> ovr_flag);

endmodule

// File: rtl/tdl_launcher.sv
module tdl_launcher
  import tdl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DEST_W = 16,
  parameter int PRIO_W = 2,
  parameter int TID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [2:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              cpl_valid,
  input  logic [TID_W-1:0]  cpl_tid,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_kind,
  output logic [TID_W-1:0]  req_tid,
  output logic [ADDR_W-1:0] req_local_addr,
  output logic [ADDR_W-1:0] req_remote_addr,
  output logic [DEST_W-1:0] req_dest_id,
  output logic [CNT_W-1:0]  req_byte_count,
  output logic [PRIO_W-1:0] req_prio,
  output logic              busy
);

  logic [ADDR_W-1:0] local_q, remote_q;
  logic [CNT_W-1:0]  count_q;
  logic [DEST_W-1:0] dest_q;
  logic [PRIO_W-1:0] prio_q;
  logic [2:0]        kind_q;
  logic [31:0]       status_word;
  logic              err_flag, ovr_flag;
  logic              seek, hold_tag, tid_free;
  logic [TID_W-1:0]  cand_tid;
  logic              launch_wr, clear_wr;

  assign launch_wr = cfg_wr_en && (cfg_idx == IDX_LAUNCH);
  assign clear_wr  = cfg_wr_en && (cfg_idx == IDX_STATUS);

  always_comb begin
    status_word    = '0;
    status_word[0] = busy;
    status_word[1] = err_flag;
    status_word[2] = ovr_flag;
  end

  tdl_desc_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEST_W(DEST_W), .PRIO_W(PRIO_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .idx(cfg_idx),
    .wr_data(cfg_wdata), .status_word(status_word),
    .local_q(local_q), .remote_q(remote_q), .count_q(count_q),
    .dest_q(dest_q), .prio_q(prio_q), .kind_q(kind_q), .rd_data(cfg_rdata)
  );

  tdl_tid_alloc #(.TID_W(TID_W)) u_tags (
    .clk(clk), .rst(rst), .seek(seek), .hold_tag(hold_tag),
    .cpl_valid(cpl_valid), .cpl_tid(cpl_tid),
    .tid_free(tid_free), .cand_tid(cand_tid)
  );

  tdl_launch_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEST_W(DEST_W), .PRIO_W(PRIO_W), .TID_W(TID_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .launch_wr(launch_wr), .launch_kind(cfg_wdata[2:0]),
    .clear_wr(clear_wr), .clear_bits(cfg_wdata[2:1]),
    .local_q(local_q), .remote_q(remote_q), .count_q(count_q),
    .dest_q(dest_q), .prio_q(prio_q),
    .tid_free(tid_free), .cand_tid(cand_tid), .req_ready(req_ready),
    .seek(seek), .hold_tag(hold_tag), .req_valid(req_valid),
    .req_kind(req_kind), .req_tid(req_tid),
    .req_local(req_local_addr), .req_remote(req_remote_addr),
    .req_count(req_byte_count), .req_dest(req_dest_id), .req_prio(req_prio),
    .busy(busy), .err_flag(err_flag), .ovr_flag(ovr_flag)
  );

  // R3
  rise_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> busy);

  // R8
  handshake_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_valid && !busy));

  // R4
  no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cfg_wr_en && cfg_idx == IDX_LAUNCH)) |=> !busy);

endmodule

// File: tb/tdl_launcher_test.sv
module tdl_launcher_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cpl_valid = 1'b0;
  logic [7:0]  cpl_tid = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [2:0]  req_kind;
  logic [7:0]  req_tid;
  logic [31:0] req_local_addr, req_remote_addr, req_byte_count;
  logic [15:0] req_dest_id;
  logic [1:0]  req_prio;
  logic        busy;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tdl_launcher uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpl_valid(cpl_valid), .cpl_tid(cpl_tid),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_tid(req_tid), .req_local_addr(req_local_addr),
    .req_remote_addr(req_remote_addr), .req_dest_id(req_dest_id),
    .req_byte_count(req_byte_count), .req_prio(req_prio), .busy(busy)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ms;          // 0 idle, 1 looking for a tag, 2 offering
  bit          outst[256];
  int          nxt;
  logic [31:0] m_reg[6];
  logic [31:0] e_loc, e_rem, e_cnt;
  logic [15:0] e_dst;
  logic [1:0]  e_pri;
  logic [2:0]  e_kind;
  logic [7:0]  e_tid;
  bit          m_err, m_ovr, rd_chk;
  logic [31:0] exp_rd;

  always @(posedge clk) begin
    int ns;
    int set_tag;
    if (rst) begin
      ms = 0; nxt = 0; m_err = 0; m_ovr = 0; rd_chk = 0; exp_rd = 0;
      foreach (outst[i]) outst[i] = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      ns = ms;
      set_tag = -1;
      rd_chk = cfg_rd_en;
      if (cfg_rd_en) begin
        if (cfg_idx < 6) exp_rd = m_reg[cfg_idx];
        else if (cfg_idx == 6) exp_rd = {29'd0, m_ovr, m_err, ms != 0};
        else exp_rd = 0;
      end
      if (ms == 2 && req_ready) ns = 0;
      if (ms == 1) begin
        if (!outst[nxt]) begin
          e_tid = nxt[7:0];
          if (e_kind == 0 || e_kind == 2 || e_kind == 4 || e_kind == 5) set_tag = nxt;
          ns = 2;
        end
        nxt = (nxt + 1) % 256;
      end
      if (cpl_valid) outst[cpl_tid] = 0;
      if (set_tag >= 0) outst[set_tag] = 1;
      if (cfg_wr_en) begin
        case (cfg_idx)
          0, 1, 2: m_reg[cfg_idx] = cfg_wdata;
          3: m_reg[3] = {16'd0, cfg_wdata[15:0]};
          4: m_reg[4] = {30'd0, cfg_wdata[1:0]};
          5: begin
            m_reg[5] = {29'd0, cfg_wdata[2:0]};
            if (ms != 0) m_ovr = 1;
            else if (cfg_wdata[2:0] > 5) m_err = 1;
            else begin
              ns = 1; e_kind = cfg_wdata[2:0];
              e_loc = m_reg[0]; e_rem = m_reg[1]; e_cnt = m_reg[2];
              e_dst = m_reg[3][15:0]; e_pri = m_reg[4][1:0];
            end
          end
          6: begin
            if (cfg_wdata[1]) m_err = 0;
            if (cfg_wdata[2]) m_ovr = 0;
          end
          default: ;
        endcase
      end
      ms = ns;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(req_valid == (ms == 2), "R3 req_valid", req_valid, ms == 2);
      check(busy == (ms != 0), "R8 busy", busy, ms != 0);
      if (ms == 2) begin
        check(req_tid == e_tid, "R9 tag", req_tid, e_tid);
        check(req_kind == e_kind, "R7 kind", req_kind, e_kind);
        check(req_local_addr == e_loc, "R7 local", req_local_addr, e_loc);
        check(req_remote_addr == e_rem, "R7 remote", req_remote_addr, e_rem);
        check(req_byte_count == e_cnt, "R7 count", req_byte_count, e_cnt);
        check(req_dest_id == e_dst, "R7 dest", req_dest_id, e_dst);
        check(req_prio == e_pri, "R7 prio", req_prio, e_pri);
      end
      if (rd_chk) check(cfg_rdata == exp_rd, "R2 readback", cfg_rdata, exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_idx = idx;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic launch(input logic [2:0] kind, output logic [7:0] tid);
    wr(3'd5, {29'd0, kind});
    tid = 8'hxx;
    for (int i = 0; i < 600 && !req_valid; i++) @(negedge clk);
    tid = req_tid;
    for (int i = 0; i < 600 && busy; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0]  t;
    bit          seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(!req_valid && !busy, "R1 outputs idle", {req_valid, busy}, 0);
    rd(3'd6, d); check(d == 0, "R1 status", d, 0);
    rd(3'd0, d); check(d == 0, "R1 local reg", d, 0);

    // R4 / R2 descriptor writes without launch
    wr(3'd0, 32'h1000_0040); wr(3'd1, 32'hA5A5_0000);
    wr(3'd2, 32'h0000_0100); wr(3'd3, 32'hFFFF_12CD);
    wr(3'd4, 32'hFFFF_FFFE);
    @(negedge clk);
    check(!busy && !req_valid, "R4 no launch", {busy, req_valid}, 0);
    rd(3'd3, d); check(d == 32'h12CD, "R2 dest field", d, 32'h12CD);
    rd(3'd4, d); check(d == 32'h2, "R2 prio field", d, 2);

    // R3 / R9 first launch
    req_ready = 1'b1;
    launch(3'd1, t);
    check(t == 8'd0, "R9 first tag", t, 0);

    // R7 fields held under back-pressure
    req_ready = 1'b0;
    wr(3'd5, 32'd3);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'hDEAD_BEEF); wr(3'd2, 32'h77);
    check(req_valid && req_local_addr == 32'h1000_0040, "R7 local held", req_local_addr, 32'h1000_0040);
    check(req_tid == 8'd1, "R9 second tag", req_tid, 1);
    req_ready = 1'b1;
    @(negedge clk);
    check(!req_valid && !busy, "R8 drop after handshake", {req_valid, busy}, 0);

    // R5 illegal kinds
    wr(3'd5, 32'd7);
    @(negedge clk);
    check(!busy, "R5 code 7 no launch", busy, 0);
    wr(3'd5, 32'd6);
    rd(3'd6, d); check(d == 32'h2, "R5 error flag", d, 2);
    wr(3'd6, 32'h2);
    rd(3'd6, d); check(d == 0, "R5 error cleared", d, 0);

    // R6 overrun
    req_ready = 1'b0;
    wr(3'd5, 32'd1);
    wr(3'd5, 32'd1);
    rd(3'd6, d); check(d == 32'h5, "R6 overrun and busy", d, 5);
    req_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R6 dropped launch", busy, 0);
    wr(3'd6, 32'h4);
    rd(3'd6, d); check(d == 0, "R6 overrun cleared", d, 0);

    // R10 reserved tag skipped across a wrap; tags 0..2 already used
    launch(3'd0, t);
    check(t == 8'd3, "R10 read tag", t, 3);
    seen = 0;
    for (int i = 0; i < 256; i++) begin
      launch((i % 2) ? 3'd1 : 3'd3, t);
      if (t == 8'd3) seen = 1;
    end
    check(!seen, "R10 reserved tag skipped", seen, 0);
    check(t == 8'd4, "R10 tag after skip", t, 4);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tid = 8'd3;
    @(negedge clk);
    cpl_valid = 1'b0;
    seen = 0;
    for (int i = 0; i < 256 && !seen; i++) begin
      launch(3'd1, t);
      if (t == 8'd3) seen = 1;
    end
    check(seen, "R10 released tag reused", seen, 1);

    // R3 other kinds launch
    launch(3'd5, t); launch(3'd4, t); launch(3'd2, t);
    check(!busy, "R3 idle after launches", busy, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule